// File: doc/BRIEF.md
# Parallel Port Extended Register Bank with Test FIFO

This block is the extended-capabilities register bank of a parallel port. It answers byte reads and writes on a three-bit offset within its own eight-byte window; decoding that window from the wider I/O address space is done outside. The bank holds three things:

- a mode-select field, with FIFO status flags in the low bits of the same register;
- a configuration-B byte;
- a shared location at offset 0. Depending on the mode, that location is a plain data byte, a constant configuration-A value, or the port into a small byte FIFO.

In FIFO-test mode the host can push bytes into the FIFO and pop them back through offset 0, and watch the empty and full flags follow the occupancy. Any write that changes the mode empties the FIFO. Moving bytes between the FIFO and the port pins is not part of this block. It provides only the register, mode and FIFO behaviour, and it exports the current mode for the transfer logic that sits next to it.

Reads are registered. The byte requested with `rd_en` appears on `rdata` one cycle later, qualified by `rd_valid`.

Top module: `ecp_xreg`

## Requirements
- R1: After reset the mode is 0 (compatible), the extended control register (offset 2) reads 0x01, and offsets 0 and 1 both read 0x00.
- R2: A write to offset 2 replaces the mode with bits 7:5 of the written value, with no OR against the old mode. Bits 4:2 are stored and read back. Bits 1:0 read back as the FIFO flags (bit 0 = empty, bit 1 = full) and ignore the written value.
- R3: In any mode other than 6 (FIFO test) or 7 (configuration), offset 0 reads back the last byte written there outside FIFO-test mode. Writes made while in FIFO-test mode do not change this byte.
- R4: In mode 6, a write to offset 0 pushes a byte and a read from offset 0 pops the oldest byte. The flags read 01 when the FIFO is empty, 00 when it is partly filled, and 10 when it holds DEPTH (default 2) bytes.
- R5: A push while the FIFO is full is dropped, and the stored bytes and flags are unchanged.
- R6: A pop while the FIFO is empty returns 0xFF and leaves the FIFO empty.
- R7: The read and write pointers wrap to zero after DEPTH-1, so the FIFO stays first-in first-out over any number of passes.
- R8: A write to offset 2 whose bits 7:5 differ from the current mode empties the FIFO (flags 01). A write that keeps the same mode leaves the FIFO contents alone.
- R9: In mode 7 (configuration), a read from offset 0 returns the configuration-A constant 0x10, which reports an 8-bit FIFO width in bits 6:4.
- R10: Offset 1 is a read/write byte. Offsets 3 to 7 read 0xFF, and writes to them change nothing.
- R11: `rd_valid` is high exactly one cycle after a cycle with `rd_en`, and `rdata` holds the read value in that cycle. If `wr_en` and `rd_en` are both high in the same cycle, the read is served and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| rd_en | input | 1 | Read strobe for one byte |
| addr | input | 3 | Register offset within the window |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle that `rdata` carries a read result |
| mode | output | 3 | Current mode code |

## Verification
The FIFO is exercised with several patterns, and each one separates a different fault:

- A fill to full followed by a drain distinguishes correct ordering from swapped slots.
- An extra push at full and an extra pop at empty show whether the boundary guards work.
- An interleaved push/pop run that crosses the end of the storage catches a pointer that fails to wrap.

Mode writes are tried both with the same mode and with a different one. This separates a flush triggered by any control write from a flush triggered only by an actual mode change. It also shows whether a new mode replaces the old one or is merged with it.

Offset 0 is read in compatible, test and configuration modes to check that the three meanings of that location are kept apart.

// File: rtl/ecp_xreg_pkg.sv
package ecp_xreg_pkg;
  typedef enum logic [2:0] {
    MD_COMPAT  = 3'd0,
    MD_BYTE    = 3'd1,
    MD_PPFIFO  = 3'd2,
    MD_ECPFIFO = 3'd3,
    MD_EPP     = 3'd4,
    MD_RSVD    = 3'd5,
    MD_TEST    = 3'd6,
    MD_CONFIG  = 3'd7
  } xmode_e;

  localparam logic [2:0] OFS_SHARED = 3'd0;
  localparam logic [2:0] OFS_CFGB   = 3'd1;
  localparam logic [2:0] OFS_XCTL   = 3'd2;

  localparam logic [7:0] CFGA_BYTE  = 8'h10;
  localparam logic [7:0] NONE_BYTE  = 8'hFF;
endpackage

// File: rtl/ecp_xreg_ctl.sv
module ecp_xreg_ctl
  import ecp_xreg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] wbyte,
  output xmode_e     mode_q,
  output logic [2:0] spare_q,
  output logic       flush
);
  xmode_e new_mode;

  assign new_mode = xmode_e'(wbyte[7:5]);
  assign flush    = we && (new_mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MD_COMPAT;
      spare_q <= 3'd0;
    end else if (we) begin
      mode_q  <= new_mode;
      spare_q <= wbyte[4:2];
    end
  end
endmodule

// File: rtl/ecp_xreg_fifo.sv
module ecp_xreg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CMAX);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ecp_xreg.sv
module ecp_xreg
  import ecp_xreg_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic [2:0] mode
);
  xmode_e     mode_q;
  logic [2:0] spare_q;
  logic       flush, fifo_empty, fifo_full;
  logic [7:0] fifo_head, data_q, cfgb_q, rd_mux;
  logic       wr_ok, in_test, push, pop;

  assign wr_ok   = wr_en && !rd_en;
  assign in_test = (mode_q == MD_TEST);
  assign push    = wr_ok && (addr == OFS_SHARED) && in_test;
  assign pop     = rd_en && (addr == OFS_SHARED) && in_test;
  assign mode    = mode_q;

  ecp_xreg_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_ok && (addr == OFS_XCTL)),
    .wbyte   (wdata),
    .mode_q  (mode_q),
    .spare_q (spare_q),
    .flush   (flush)
  );

  ecp_xreg_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .push  (push),
    .din   (wdata),
    .pop   (pop),
    .head  (fifo_head),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 8'h00;
      cfgb_q <= 8'h00;
    end else if (wr_ok) begin
      if (addr == OFS_SHARED && !in_test) data_q <= wdata;
      if (addr == OFS_CFGB)               cfgb_q <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_SHARED: begin
        if (in_test)                 rd_mux = fifo_empty ? NONE_BYTE : fifo_head;
        else if (mode_q == MD_CONFIG) rd_mux = CFGA_BYTE;
        else                         rd_mux = data_q;
      end
      OFS_CFGB: rd_mux = cfgb_q;
      OFS_XCTL: rd_mux = {mode_q, spare_q, fifo_full, fifo_empty};
      default:  rd_mux = NONE_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= 8'h00;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/ecp_xreg_chk.sv
module ecp_xreg_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       rd_valid,
  input logic [2:0] mode,
  input logic       empty,
  input logic       full
);
  // R1
  reset_mode_chk: assert property (@(posedge clk) rst |=> (mode == 3'd0 && !rd_valid));

  // R11
  rd_resp_chk: assert property (@(posedge clk) disable iff (rst) rd_en |=> rd_valid);

  // R11
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (rst) !rd_en |=> !rd_valid);

  // R4
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({empty, full}));

  // R5
  full_push_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && addr == 3'd0 && mode == 3'd6) |=> full);

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && addr == 3'd0 && mode == 3'd6) |=> (rdata == 8'hFF && empty));

  // R8
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && addr == 3'd2 && wdata[7:5] != mode) |=> (empty && mode == $past(wdata[7:5])));
endmodule

bind ecp_xreg ecp_xreg_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .rd_valid (rd_valid),
  .mode     (mode),
  .empty    (fifo_empty),
  .full     (fifo_full)
);

// File: tb/test_ecp_xreg.sv
`timescale 1ns/1ps
module test_ecp_xreg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rd_valid;
  logic [2:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  ecp_xreg i_ecp_xreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .mode(mode)
  );

  task automatic access(input bit w, input bit r, input logic [2:0] a,
                        input logic [7:0] d, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) begin it.exp = e; it.tag = tag; sb.push_back(it); end
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    access(1'b1, 1'b0, a, d, 8'h00, "");
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    access(1'b0, 1'b1, a, 8'h00, e, tag);
  endtask

  task automatic chk_mode(input logic [2:0] e, input string tag);
    checks++;
    if (mode !== e) begin
      errors++;
      $display("FAIL %s mode actual=%0d expected=%0d", tag, mode, e);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      item_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected response actual=%02h expected=none", rdata);
      end else begin
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%02h expected=%02h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk_mode(3'd0, "R1");
    rd(3'd2, 8'h01, "R1 ctl");
    rd(3'd0, 8'h00, "R1 data");
    rd(3'd1, 8'h00, "R1 cfgb");
    // R10 unused offsets
    for (int k = 3; k < 8; k++) rd(3'(k), 8'hFF, "R10 unused");
    wr(3'd5, 8'h33);
    wr(3'd3, 8'hE0);
    rd(3'd5, 8'hFF, "R10 write ignored");
    rd(3'd2, 8'h01, "R10 ctl untouched");
    wr(3'd1, 8'h5C);
    rd(3'd1, 8'h5C, "R10 cfgb");
    // R3 plain data register
    wr(3'd0, 8'hA5);
    rd(3'd0, 8'hA5, "R3 data");
    // R2 spare bits, read-only flags
    wr(3'd2, 8'h1F);
    rd(3'd2, 8'h1D, "R2 ctl");
    chk_mode(3'd0, "R2");
    // R4 test mode
    wr(3'd2, 8'hC0);
    chk_mode(3'd6, "R2 replace");
    rd(3'd2, 8'hC1, "R4 empty");
    wr(3'd0, 8'h11);
    rd(3'd2, 8'hC0, "R4 partial");
    wr(3'd0, 8'h22);
    rd(3'd2, 8'hC2, "R4 full");
    wr(3'd0, 8'h33);
    rd(3'd2, 8'hC2, "R5 still full");
    rd(3'd0, 8'h11, "R4 pop1");
    rd(3'd0, 8'h22, "R5 pop2");
    rd(3'd2, 8'hC1, "R4 empty again");
    rd(3'd0, 8'hFF, "R6 pop empty");
    rd(3'd2, 8'hC1, "R6 still empty");
    // R7 wrap
    wr(3'd0, 8'h44);
    rd(3'd0, 8'h44, "R7 a");
    wr(3'd0, 8'h55);
    wr(3'd0, 8'h66);
    rd(3'd0, 8'h55, "R7 b");
    rd(3'd0, 8'h66, "R7 c");
    // R8 same mode keeps contents
    wr(3'd0, 8'h77);
    wr(3'd2, 8'hC0);
    rd(3'd2, 8'hC0, "R8 same mode");
    rd(3'd0, 8'h77, "R8 kept");
    // R8 change flushes
    wr(3'd0, 8'h88);
    wr(3'd2, 8'h20);
    chk_mode(3'd1, "R2 new mode");
    rd(3'd2, 8'h21, "R8 flushed");
    rd(3'd0, 8'hA5, "R3 untouched by pushes");
    wr(3'd2, 8'hC0);
    rd(3'd0, 8'hFF, "R8 nothing left");
    // R9 config mode
    wr(3'd2, 8'hE0);
    chk_mode(3'd7, "R9");
    rd(3'd0, 8'h10, "R9 cfga");
    // R11 simultaneous access
    access(1'b1, 1'b1, 3'd1, 8'h99, 8'h5C, "R11 read wins");
    rd(3'd1, 8'h5C, "R11 write dropped");
    repeat (4) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R11 missing responses actual=%0d expected=0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule